// File: doc/BRIEF.md
# GPIO Pad Event Interrupt Controller

This block manages a bank of general-purpose pads that are split into equal-sized groups. Every pad has its own configuration word. The word selects the pad function and the output drive. It also selects how the incoming signal is turned into an interrupt event: level, rising edge, both edges, or off. A separate invert bit turns rising into falling and active-high into active-low. Every pad input passes through a two-flop synchronizer before any detection takes place.

Each group keeps five per-pad bit registers:

- interrupt status, which is write-one-to-clear;
- interrupt enable;
- wake status, which is write-one-to-clear;
- wake enable;
- host ownership.

A detected event sets the pad's interrupt status bit only when the host owns that pad. One interrupt line is raised while any pad, in any group, has both its status bit and its enable bit set. A second output, for wake, is raised while any wake status bit is set.

Software reaches every register through a simple single-cycle write port and a combinational read port. The word address map is as follows:

| Address | Register |
|---|---|
| `0x00 + pad` | Pad configuration word |
| `0x40 + 8*group + 0` | Interrupt status |
| `0x40 + 8*group + 1` | Interrupt enable |
| `0x40 + 8*group + 2` | Wake status |
| `0x40 + 8*group + 3` | Wake enable |
| `0x40 + 8*group + 4` | Host ownership |

The block has no state machine. Its behaviour is held in a few per-pad and per-group registers, so there are no states or transitions to name.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: After reset:
  - every pad configuration word reads `0x404` (event selector off, transmit disabled), with bit 1 set when the synchronized input is high;
  - interrupt status, interrupt enable, wake status and wake enable read 0;
  - host ownership reads all ones for valid pads;
  - `irq_o`, `wake_o` and every `pad_oe` bit are 0.
- R2: Configuration bits [10:9] select the event type.
  - Value 0 is level. In level mode the status bit is set on every cycle that the (possibly inverted) input is high.
  - A clear written while that level is still high therefore has no lasting effect.
  - Once the level has gone, a clear removes the bit.
- R3: Selector value 1 is edge mode, which sets status on a 0-to-1 change of the inverted input. Bit 8 inverts the input, so that edge mode with bit 8 set detects falling edges and level mode with bit 8 set is active-low.
- R4: Selector value 3 sets status on any change of the synchronized input, in either direction.
- R5: Selector value 2 never sets status, whatever the input does.
- R6: Writing a mask to the interrupt status register clears exactly the bits that are set in the mask. If an event hits the same bit in the same cycle, the event wins and the bit stays set.
- R7: `irq_o` is high exactly when some pad, in any group, has both its interrupt status bit and its interrupt enable bit set.
- R8: Bit positions of the last group that lie at or beyond the total pad count never read as set, in any group register, even after they are written with ones.
- R9: While a pad's host-ownership bit is clear, that pad's interrupt status bit is never set.
- R10: A pad event sets the pad's wake status bit only when its wake enable bit is set and its configuration bit 11 (route to SCI) is clear. Wake status is write-one-to-clear. `wake_o` is high while any wake status bit is set.
- R11: `pad_oe` equals (mode bits [7:4] == 0) and not transmit-disable (bit 2), and `pad_out` carries bit 0 while `pad_oe` is high. `pad_native` flags a nonzero mode.
- R12: Configuration bit 1 shows the synchronized input and cannot be written. Receive-disable (bit 3) forces bit 1 to read 0 and blocks all events from that pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pad_in | input | NUM_PADS | Raw pad inputs, asynchronous |
| pad_out | output | NUM_PADS | Pad output values |
| pad_oe | output | NUM_PADS | Pad output enables |
| pad_native | output | NUM_PADS | Pad is in a native (non-GPIO) function |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Wake request |

## Verification
The assertions assume two things about the inputs:

- `reset` is held for at least one clock edge before any check applies.
- Register writes hold a stable address and data across the clock edge that captures them.

The bench meets both conditions by driving every input on the falling clock edge, and by changing a pad input only after the event selector is already configured, or only while the selector is off. It waits long enough for the synchronizer to catch up before it expects any status change, and it never relies on an input pulse shorter than one clock cycle, because such a pulse could be lost in the synchronizer.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    typedef enum logic [1:0] {
        EV_LEVEL = 2'd0,
        EV_EDGE  = 2'd1,
        EV_OFF   = 2'd2,
        EV_BOTH  = 2'd3
    } evt_sel_e;

    // Pad configuration word, MSB first: bit 11 down to bit 0.
    typedef struct packed {
        logic       sci_route;  // 11
        evt_sel_e   evt_sel;    // 10:9
        logic       rx_inv;     // 8
        logic [3:0] mode;       // 7:4
        logic       rx_dis;     // 3
        logic       tx_dis;     // 2
        logic       rx_state;   // 1, read-only
        logic       tx_state;   // 0
    } pad_cfg_t;

    localparam int CFG_W = $bits(pad_cfg_t);

    localparam pad_cfg_t PAD_CFG_RST = '{
        sci_route: 1'b0,
        evt_sel:   EV_OFF,
        rx_inv:    1'b0,
        mode:      4'd0,
        rx_dis:    1'b0,
        tx_dis:    1'b1,
        rx_state:  1'b0,
        tx_state:  1'b0
    };

    typedef enum logic [2:0] {
        GR_ISTAT = 3'd0,
        GR_IEN   = 3'd1,
        GR_WSTAT = 3'd2,
        GR_WEN   = 3'd3,
        GR_OWN   = 3'd4
    } grp_reg_e;

    localparam int GRP_REGS   = 5;
    localparam int GRP_BASE   = 'h40;
    localparam int GRP_STRIDE = 8;

endpackage

// File: rtl/gpio_evt_pad.sv
module gpio_evt_pad
    import gpio_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              pad_in,
    output pad_cfg_t          cfg_rd,
    output logic              evt,
    output logic              wake_qual,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              pad_native
);

    logic     sync_q1, sync_q2, prev_q;
    pad_cfg_t cfg_q;
    pad_cfg_t cfg_wr;
    logic     cur_lvl, old_lvl;

    // two-flop synchronizer plus one history flop for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q1 <= 1'b0;
            sync_q2 <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync_q1 <= pad_in;
            sync_q2 <= sync_q1;
            prev_q  <= sync_q2;
        end
    end

    always_comb begin
        cfg_wr          = pad_cfg_t'(cfg_wdata);
        cfg_wr.rx_state = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= PAD_CFG_RST;
        else if (cfg_we)
            cfg_q <= cfg_wr;
    end

    // both samples are inverted, so toggling the invert bit makes no edge
    assign cur_lvl = sync_q2 ^ cfg_q.rx_inv;
    assign old_lvl = prev_q  ^ cfg_q.rx_inv;

    always_comb begin
        evt = 1'b0;
        unique case (cfg_q.evt_sel)
            EV_LEVEL: evt = cur_lvl;
            EV_EDGE:  evt = cur_lvl & ~old_lvl;
            EV_OFF:   evt = 1'b0;
            EV_BOTH:  evt = cur_lvl ^ old_lvl;
            default:  evt = 1'b0;
        endcase
        if (cfg_q.rx_dis)
            evt = 1'b0;
    end

    always_comb begin
        cfg_rd          = cfg_q;
        cfg_rd.rx_state = sync_q2 & ~cfg_q.rx_dis;
    end

    assign wake_qual  = ~cfg_q.sci_route;
    assign pad_native = (cfg_q.mode != 4'd0);
    assign pad_oe     = ~pad_native & ~cfg_q.tx_dis;
    assign pad_out    = pad_oe & cfg_q.tx_state;

    // R11: a native function never lets the GPIO driver through
    p_native_no_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pad_native |-> (!pad_oe && !pad_out));

    // R12: receive-disable silences the pad
    p_rxdis_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.rx_dis |-> (!evt && !cfg_rd.rx_state));

    // R5: the off selector produces no event
    p_off_no_evt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.evt_sel == EV_OFF) |-> !evt);

endmodule

// File: rtl/gpio_evt_grp.sv
module gpio_evt_grp
    import gpio_evt_pkg::*;
#(
    parameter int GRP_SIZE  = 8,
    parameter int VALID_CNT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [GRP_REGS-1:0]  reg_we,
    input  logic [GRP_SIZE-1:0]  wbits,
    input  logic [GRP_SIZE-1:0]  evt,
    input  logic [GRP_SIZE-1:0]  wake_qual,
    output logic [GRP_SIZE-1:0]  istat,
    output logic [GRP_SIZE-1:0]  ien,
    output logic [GRP_SIZE-1:0]  wstat,
    output logic [GRP_SIZE-1:0]  wen,
    output logic [GRP_SIZE-1:0]  own
);

    logic [GRP_SIZE-1:0] valid;
    logic [GRP_SIZE-1:0] ist_set, ist_clr, wst_set, wst_clr;

    for (genvar b = 0; b < GRP_SIZE; b++) begin : g_valid
        assign valid[b] = (b < VALID_CNT);
    end

    assign ist_set = evt & own & valid;
    assign ist_clr = reg_we[GR_ISTAT] ? wbits : '0;
    assign wst_set = evt & wen & wake_qual & valid;
    assign wst_clr = reg_we[GR_WSTAT] ? wbits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            istat <= '0;
            wstat <= '0;
            ien   <= '0;
            wen   <= '0;
            own   <= valid;
        end else begin
            istat <= (istat & ~ist_clr) | ist_set;
            wstat <= (wstat & ~wst_clr) | wst_set;
            if (reg_we[GR_IEN]) ien <= wbits & valid;
            if (reg_we[GR_WEN]) wen <= wbits & valid;
            if (reg_we[GR_OWN]) own <= wbits & valid;
        end
    end

    // R6: an event on a bit being cleared keeps the bit set
    p_evt_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|ist_set) |=> ((istat & $past(ist_set)) == $past(ist_set)));

    // R6: masked bits without a concurrent event are cleared
    p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ist_clr & ~ist_set)) |=> ((istat & $past(ist_clr & ~ist_set)) == '0));

    // R9: a non-owned pad never gains a status bit
    p_own_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((istat & ~$past(istat) & ~$past(own)) == '0));

    // R10: a newly set wake bit needs its wake enable
    p_wake_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((wstat & ~$past(wstat) & ~$past(wen)) == '0));

    // R8: padding bits of a short group stay clear
    p_pad_bits_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (((istat | wstat | ien | wen | own) & ~valid) == '0));

endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PADS = 12,
    parameter int GRP_SIZE = 8,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NUM_PADS-1:0]  pad_in,
    output logic [NUM_PADS-1:0]  pad_out,
    output logic [NUM_PADS-1:0]  pad_oe,
    output logic [NUM_PADS-1:0]  pad_native,
    output logic                 irq_o,
    output logic                 wake_o
);

    localparam int NUM_GRPS = (NUM_PADS + GRP_SIZE - 1) / GRP_SIZE;
    localparam int FLAT_W   = NUM_GRPS * GRP_SIZE;

    pad_cfg_t             cfg_rd [NUM_PADS];
    logic [FLAT_W-1:0]    evt_flat, wq_flat;
    logic [GRP_SIZE-1:0]  istat [NUM_GRPS];
    logic [GRP_SIZE-1:0]  ien   [NUM_GRPS];
    logic [GRP_SIZE-1:0]  wstat [NUM_GRPS];
    logic [GRP_SIZE-1:0]  wen   [NUM_GRPS];
    logic [GRP_SIZE-1:0]  own   [NUM_GRPS];
    logic [NUM_GRPS-1:0]  grp_irq, grp_wake;

    // ---------------- pads ----------------
    for (genvar p = 0; p < FLAT_W; p++) begin : g_pad
        if (p < NUM_PADS) begin : g_real
            logic pad_we;
            assign pad_we = reg_we && (reg_addr == ADDR_W'(p));
            gpio_evt_pad u_pad (
                .clk        (clk),
                .rst_n      (rst_n),
                .cfg_we     (pad_we),
                .cfg_wdata  (reg_wdata[CFG_W-1:0]),
                .pad_in     (pad_in[p]),
                .cfg_rd     (cfg_rd[p]),
                .evt        (evt_flat[p]),
                .wake_qual  (wq_flat[p]),
                .pad_out    (pad_out[p]),
                .pad_oe     (pad_oe[p]),
                .pad_native (pad_native[p])
            );
        end else begin : g_fill
            assign evt_flat[p] = 1'b0;
            assign wq_flat[p]  = 1'b0;
        end
    end

    // ---------------- groups ----------------
    for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
        localparam int LEFT = NUM_PADS - g * GRP_SIZE;
        localparam int VCNT = (LEFT > GRP_SIZE) ? GRP_SIZE : LEFT;
        logic [GRP_REGS-1:0] gwe;

        for (genvar k = 0; k < GRP_REGS; k++) begin : g_we
            assign gwe[k] = reg_we &&
                (reg_addr == ADDR_W'(GRP_BASE + g * GRP_STRIDE + k));
        end

        gpio_evt_grp #(
            .GRP_SIZE  (GRP_SIZE),
            .VALID_CNT (VCNT)
        ) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .reg_we    (gwe),
            .wbits     (reg_wdata[GRP_SIZE-1:0]),
            .evt       (evt_flat[g*GRP_SIZE +: GRP_SIZE]),
            .wake_qual (wq_flat[g*GRP_SIZE +: GRP_SIZE]),
            .istat     (istat[g]),
            .ien       (ien[g]),
            .wstat     (wstat[g]),
            .wen       (wen[g]),
            .own       (own[g])
        );

        assign grp_irq[g]  = |(istat[g] & ien[g]);
        assign grp_wake[g] = |wstat[g];
    end

    assign irq_o  = |grp_irq;
    assign wake_o = |grp_wake;

    // ---------------- read mux ----------------
    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < NUM_PADS; p++) begin
            if (reg_addr == ADDR_W'(p))
                reg_rdata = DATA_W'(cfg_rd[p]);
        end
        for (int g = 0; g < NUM_GRPS; g++) begin
            if (reg_addr == ADDR_W'(GRP_BASE + g * GRP_STRIDE + int'(GR_ISTAT)))
                reg_rdata = DATA_W'(istat[g]);
            if (reg_addr == ADDR_W'(GRP_BASE + g * GRP_STRIDE + int'(GR_IEN)))
                reg_rdata = DATA_W'(ien[g]);
            if (reg_addr == ADDR_W'(GRP_BASE + g * GRP_STRIDE + int'(GR_WSTAT)))
                reg_rdata = DATA_W'(wstat[g]);
            if (reg_addr == ADDR_W'(GRP_BASE + g * GRP_STRIDE + int'(GR_WEN)))
                reg_rdata = DATA_W'(wen[g]);
            if (reg_addr == ADDR_W'(GRP_BASE + g * GRP_STRIDE + int'(GR_OWN)))
                reg_rdata = DATA_W'(own[g]);
        end
    end

    // R7: a rising interrupt comes from a status or enable change
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(reg_we) || $past(|evt_flat)));

    // R10: wake only rises after a pad event
    p_wake_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> $past(|evt_flat));

endmodule

// File: tb/gpio_evt_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_evt_ctrl_tb_top;

    localparam int NP = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe, pad_native;
    logic          irq_o, wake_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gpio_evt_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_native(pad_native),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    // {cfg[11:0], start, end, expected status, unused}
    localparam int NV = 16;
    localparam logic [15:0] VEC [NV] = '{
        {12'h004, 1'b0, 1'b1, 1'b1, 1'b0},  // R2 level high
        {12'h004, 1'b1, 1'b0, 1'b1, 1'b0},  // R2 level, clear overridden
        {12'h004, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 level idle
        {12'h104, 1'b1, 1'b1, 1'b0, 1'b0},  // R3 active-low held high
        {12'h104, 1'b1, 1'b0, 1'b1, 1'b0},  // R3 active-low goes low
        {12'h204, 1'b0, 1'b1, 1'b1, 1'b0},  // R3 rising
        {12'h204, 1'b1, 1'b0, 1'b0, 1'b0},  // R3 falling ignored
        {12'h304, 1'b1, 1'b0, 1'b1, 1'b0},  // R3 inverted falling
        {12'h304, 1'b0, 1'b1, 1'b0, 1'b0},  // R3 inverted rising ignored
        {12'h404, 1'b0, 1'b1, 1'b0, 1'b0},  // R5 off
        {12'h404, 1'b1, 1'b0, 1'b0, 1'b0},  // R5 off
        {12'h604, 1'b0, 1'b1, 1'b1, 1'b0},  // R4 rise
        {12'h604, 1'b1, 1'b0, 1'b1, 1'b0},  // R4 fall
        {12'h704, 1'b1, 1'b0, 1'b1, 1'b0},  // R4 inverted fall
        {12'h604, 1'b1, 1'b1, 1'b0, 1'b0},  // R4 steady
        {12'h604, 1'b0, 1'b0, 1'b0, 1'b0}   // R4 steady low
    };

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); chk(v == 32'h404, "R1 pad cfg", v, 32'h404);
        rd(8'h40, v); chk(v == 0, "R1 istat", v, 0);
        rd(8'h41, v); chk(v == 0, "R1 ien", v, 0);
        rd(8'h4C, v); chk(v == 32'h0F, "R1 own g1", v, 32'h0F);
        chk({irq_o, wake_o} == 2'b00, "R1 irq/wake", {irq_o, wake_o}, 0);
        chk(pad_oe == '0, "R1 pad_oe", 32'(pad_oe), 0);

        // Vector walk on pad 0
        for (int i = 0; i < NV; i++) begin
            wr(8'h00, 32'h404);
            pad_in[0] = VEC[i][3];
            settle();
            wr(8'h40, 32'hFF);
            wr(8'h00, 32'(VEC[i][15:4]));
            settle();
            wr(8'h40, 32'h01);
            pad_in[0] = VEC[i][2];
            settle();
            rd(8'h40, v);
            chk(v[0] == VEC[i][1], $sformatf("R2/R3/R4/R5 vector %0d", i),
                32'(v[0]), 32'(VEC[i][1]));
        end

        // R6: mask clears only selected bits
        wr(8'h01, 32'h204); wr(8'h02, 32'h204);
        pad_in[2:1] = 2'b11;
        settle();
        rd(8'h40, v); chk((v & 32'h06) == 32'h06, "R6 both set", v & 32'h06, 32'h06);
        wr(8'h40, 32'h02);
        rd(8'h40, v); chk((v & 32'h06) == 32'h04, "R6 partial clear", v & 32'h06, 32'h04);
        // R2/R6: level high beats the clear
        wr(8'h03, 32'h004);
        pad_in[3] = 1'b1;
        settle();
        wr(8'h40, 32'h08);
        rd(8'h40, v); chk(v[3] == 1'b1, "R2 level survives clear", 32'(v[3]), 1);
        pad_in[3] = 1'b0;
        settle();
        wr(8'h40, 32'h08);
        rd(8'h40, v); chk(v[3] == 1'b0, "R2 clear after level gone", 32'(v[3]), 0);

        // R7: combined interrupt
        pad_in[1] = 1'b0; pad_in[9] = 1'b0;
        settle();
        wr(8'h40, 32'hFF); wr(8'h48, 32'hFF);
        pad_in[1] = 1'b1;
        settle();
        chk(irq_o == 1'b0, "R7 masked", 32'(irq_o), 0);
        wr(8'h41, 32'h02);
        #1 chk(irq_o == 1'b1, "R7 enabled", 32'(irq_o), 1);
        wr(8'h40, 32'h02);
        #1 chk(irq_o == 1'b0, "R7 cleared", 32'(irq_o), 0);
        wr(8'h09, 32'h204); wr(8'h49, 32'h02);
        pad_in[9] = 1'b1;
        settle();
        chk(irq_o == 1'b1, "R7 second group", 32'(irq_o), 1);

        // R8: padding bits of last group
        wr(8'h49, 32'hFF);
        rd(8'h49, v); chk(v == 32'h0F, "R8 ien padding", v, 32'h0F);
        wr(8'h4B, 32'hFF);
        rd(8'h4B, v); chk(v == 32'h0F, "R8 wen padding", v, 32'h0F);
        wr(8'h4B, 32'h00);
        rd(8'h48, v); chk((v & 32'hF0) == 0, "R8 istat padding", v, 0);

        // R9: ownership blocks status
        wr(8'h44, 32'hEF); wr(8'h04, 32'h204);
        pad_in[4] = 1'b1;
        settle();
        rd(8'h40, v); chk(v[4] == 1'b0, "R9 not owned", 32'(v[4]), 0);
        wr(8'h44, 32'hFF);
        pad_in[4] = 1'b0; settle();
        pad_in[4] = 1'b1; settle();
        rd(8'h40, v); chk(v[4] == 1'b1, "R9 owned", 32'(v[4]), 1);

        // R10: wake
        wr(8'h43, 32'h20); wr(8'h05, 32'h204);
        pad_in[5] = 1'b1;
        settle();
        rd(8'h42, v); chk(v[5] == 1'b1, "R10 wake status", 32'(v[5]), 1);
        chk(wake_o == 1'b1, "R10 wake_o", 32'(wake_o), 1);
        wr(8'h42, 32'h20);
        rd(8'h42, v); chk(v == 0, "R10 wake cleared", v, 0);
        chk(wake_o == 1'b0, "R10 wake_o low", 32'(wake_o), 0);
        wr(8'h05, 32'hA04);
        pad_in[5] = 1'b0; settle();
        pad_in[5] = 1'b1; settle();
        rd(8'h42, v); chk(v == 0, "R10 routed away", v, 0);

        // R11: output path
        wr(8'h06, 32'h001);
        #1 chk({pad_oe[6], pad_out[6], pad_native[6]} == 3'b110, "R11 gpio drive",
               32'({pad_oe[6], pad_out[6], pad_native[6]}), 32'h6);
        wr(8'h06, 32'h011);
        #1 chk({pad_oe[6], pad_out[6], pad_native[6]} == 3'b001, "R11 native",
               32'({pad_oe[6], pad_out[6], pad_native[6]}), 32'h1);

        // R12: receive state
        pad_in[7] = 1'b1; settle();
        rd(8'h07, v); chk(v == 32'h406, "R12 rx high", v, 32'h406);
        wr(8'h07, 32'h406);
        pad_in[7] = 1'b0; settle();
        rd(8'h07, v); chk(v == 32'h404, "R12 rx not writable", v, 32'h404);
        wr(8'h40, 32'hFF);
        wr(8'h07, 32'h20C);
        pad_in[7] = 1'b1; settle();
        rd(8'h07, v); chk(v == 32'h20C, "R12 rx disabled reads 0", v, 32'h20C);
        rd(8'h40, v); chk(v[7] == 1'b0, "R12 rx disabled no event", 32'(v[7]), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule